// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Status Queue

This block takes in an asynchronous serial line and recovers characters from it. A free-running tick at sixteen times the bit rate paces the receiver. A falling edge on the idle-high line starts a frame. The receiver checks at mid-bit that the line is still low, then samples each later bit at its centre. Data bits come in least significant bit first. Runtime inputs set the character length (5 to 8 bits), an optional parity bit (even or odd) and one or two stop bits.

Each finished character is stored in a sixteen-slot queue together with four status flags: break, overrun, parity error and framing error. The consuming side sees the oldest entry at all times. A one-cycle pop strobe removes that entry. Empty and full indications let the consumer poll the queue. The line is passed through a short synchronizer before any sampling.

Top module: `serial_rx_queue`

## Requirements
- R1: A frame is one low start bit, then 5, 6, 7 or 8 data bits (cfg_len codes 0, 1, 2, 3), an optional parity bit, then one or two high stop bits. Data bits arrive least significant bit first. The stored value is right-justified, and data bits above the configured length read as zero.
- R2: A low level is accepted as a start bit only if the line is still low at the eighth tick after the edge was seen. A shorter low pulse stores nothing.
- R3: With cfg_par_en set, the bit after the data is parity. cfg_par_odd=0 expects an even number of ones across data and parity, and cfg_par_odd=1 expects an odd number. A mismatch sets the entry's parity-error flag. With parity off the flag is 0.
- R4: If the line is low at the mid-point of the first stop bit, the entry's framing-error flag is set. The receiver then waits for the line to go high before it looks for a new start bit.
- R5: If every data bit, the parity bit if enabled, and the first stop bit are all low (the line held low for longer than a frame), the entry has the break flag and the framing flag set and data 0. Only one entry is stored until the line returns high.
- R6: The queue holds 16 entries and returns them in arrival order. fifo_empty is 1 exactly when no entry is held. fifo_full is 1 exactly when 16 entries are held.
- R7: A character that completes while 16 entries are held is discarded. The overrun flag is set on the newest stored entry, and all stored data is kept.
- R8: A pop strobe while the queue is empty has no effect. The queue stays empty, and the next stored character is read correctly.
- R9: After reset the queue is empty (fifo_empty=1, fifo_full=0).
- R10: With cfg_two_stop set, a low line at the mid-point of the second stop bit also sets the framing-error flag, without the break flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data length code: 0..3 gives 5..8 bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| pop | input | 1 | Remove the oldest entry |
| rd_data | output | 8 | Data of oldest entry |
| rd_brk | output | 1 | Break flag of oldest entry |
| rd_ovr | output | 1 | Overrun flag of oldest entry |
| rd_par | output | 1 | Parity-error flag of oldest entry |
| rd_frm | output | 1 | Framing-error flag of oldest entry |
| fifo_empty | output | 1 | No entry held |
| fifo_full | output | 1 | All 16 entries held |

## Verification
The embedded assertions watch invariants that must hold on every cycle. The occupancy never exceeds the depth. A push into an empty queue makes it non-empty, a pop on an empty queue and a rejected push leave the occupancy unchanged, and a store pulse lasts exactly one cycle. A stored break entry always carries zero data and the framing flag, and short words never carry stray high bits. Only the bench's scenarios can show the parts that depend on serial timing and history. These are least-significant-first assembly, parity and stop-bit judgement under each configuration, rejection of a glitch, a single entry for a long break, and the overrun flag landing on the sixteenth entry after a seventeenth frame.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef struct packed {
        logic       brk;
        logic       ovr;
        logic       par;
        logic       frm;
        logic [7:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_WAIT_HIGH
    } rx_state_e;

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
    import serial_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rx,
    input  logic [1:0] cfg_len,
    input  logic      cfg_par_en,
    input  logic      cfg_par_odd,
    input  logic      cfg_two_stop,
    output logic      push,
    output rx_entry_t entry
);
    localparam int TW = $clog2(OSR);
    localparam logic [TW-1:0] MID  = TW'(OSR / 2 - 1);
    localparam logic [TW-1:0] LAST = TW'(OSR - 1);

    typedef struct packed {
        rx_state_e  st;
        logic [TW-1:0] tcnt;
        logic [2:0] bidx;
        logic [7:0] shreg;
        logic       parx;
        logic       perr;
        logic       allz;
        logic       stop2;
        logic       push;
        rx_entry_t  ent;
    } frame_t;

    frame_t r_q, r_d;
    logic [2:0] last_bit;

    assign last_bit = 3'(cfg_len) + 3'd4;

    always_comb begin
        r_d      = r_q;
        r_d.push = 1'b0;
        if (tick) begin
            case (r_q.st)
                S_IDLE: begin
                    if (!rx) begin
                        r_d.st   = S_START;
                        r_d.tcnt = '0;
                    end
                end
                S_START: begin
                    if (r_q.tcnt == MID) begin
                        r_d.tcnt = '0;
                        if (!rx) begin
                            r_d.st    = S_DATA;
                            r_d.bidx  = '0;
                            r_d.shreg = '0;
                            r_d.parx  = 1'b0;
                            r_d.perr  = 1'b0;
                            r_d.allz  = 1'b1;
                            r_d.stop2 = 1'b0;
                        end else begin
                            r_d.st = S_IDLE;
                        end
                    end else begin
                        r_d.tcnt = r_q.tcnt + 1'b1;
                    end
                end
                S_DATA: begin
                    if (r_q.tcnt == LAST) begin
                        r_d.tcnt           = '0;
                        r_d.shreg[r_q.bidx] = rx;
                        r_d.parx           = r_q.parx ^ rx;
                        r_d.allz           = r_q.allz & ~rx;
                        if (r_q.bidx == last_bit) r_d.st = cfg_par_en ? S_PAR : S_STOP;
                        else                      r_d.bidx = r_q.bidx + 1'b1;
                    end else begin
                        r_d.tcnt = r_q.tcnt + 1'b1;
                    end
                end
                S_PAR: begin
                    if (r_q.tcnt == LAST) begin
                        r_d.tcnt = '0;
                        r_d.perr = r_q.parx ^ rx ^ cfg_par_odd;
                        r_d.allz = r_q.allz & ~rx;
                        r_d.st   = S_STOP;
                    end else begin
                        r_d.tcnt = r_q.tcnt + 1'b1;
                    end
                end
                S_STOP: begin
                    if (r_q.tcnt == LAST) begin
                        r_d.tcnt = '0;
                        if (!rx || !cfg_two_stop || r_q.stop2) begin
                            r_d.push     = 1'b1;
                            r_d.ent.data = r_q.shreg;
                            r_d.ent.par  = r_q.perr;
                            r_d.ent.frm  = ~rx;
                            r_d.ent.brk  = ~rx & r_q.allz & ~r_q.stop2;
                            r_d.ent.ovr  = 1'b0;
                            r_d.st       = rx ? S_IDLE : S_WAIT_HIGH;
                        end else begin
                            r_d.stop2 = 1'b1;
                        end
                    end else begin
                        r_d.tcnt = r_q.tcnt + 1'b1;
                    end
                end
                S_WAIT_HIGH: begin
                    if (rx) r_d.st = S_IDLE;
                end
                default: r_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign push  = r_q.push;
    assign entry = r_q.ent;

    // R1
    short_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && cfg_len == 2'd0 |-> entry.data[7:5] == 3'b000);
    // R5
    break_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && entry.brk |-> entry.frm && entry.data == 8'h00);
    // R6
    single_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push);
    // R2
    push_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(push) |-> $past(tick));
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
    import serial_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  rx_entry_t wdata,
    input  logic      pop,
    output rx_entry_t rdata,
    output logic      empty,
    output logic      full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t      p_q, p_d;
    rx_entry_t mem [DEPTH];
    logic      do_pop, do_push, ovr_hit;
    logic [AW-1:0] newest;

    always_comb begin
        p_d     = p_q;
        do_pop  = pop && (p_q.cnt != '0);
        do_push = push && ((p_q.cnt != CW'(DEPTH)) || do_pop);
        ovr_hit = push && !do_push;
        newest  = (p_q.wptr == '0) ? TOP : p_q.wptr - 1'b1;
        if (do_push) p_d.wptr = (p_q.wptr == TOP) ? '0 : p_q.wptr + 1'b1;
        if (do_pop)  p_d.rptr = (p_q.rptr == TOP) ? '0 : p_q.rptr + 1'b1;
        case ({do_push, do_pop})
            2'b10:   p_d.cnt = p_q.cnt + 1'b1;
            2'b01:   p_d.cnt = p_q.cnt - 1'b1;
            default: p_d.cnt = p_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[p_q.wptr] <= wdata;
        if (ovr_hit) mem[newest].ovr <= 1'b1;
    end

    assign rdata = mem[p_q.rptr];
    assign empty = (p_q.cnt == '0);
    assign full  = (p_q.cnt == CW'(DEPTH));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p_q.cnt <= CW'(DEPTH));
    // R6
    fill_from_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && empty && !pop |=> !empty);
    // R7
    overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop |=> full && $stable(p_q.wptr));
    // R8
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop && empty && !push |=> empty && $stable(p_q.rptr));
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
    import serial_rx_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_two_stop,
    input  logic       pop,
    output logic [7:0] rd_data,
    output logic       rd_brk,
    output logic       rd_ovr,
    output logic       rd_par,
    output logic       rd_frm,
    output logic       fifo_empty,
    output logic       fifo_full
);
    logic      rx_s;
    logic      f_push;
    rx_entry_t f_ent, q_ent;

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rx_s)
    );

    serial_rx_frame #(.OSR(OVERSAMPLE)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rx(rx_s),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .push(f_push), .entry(f_ent)
    );

    serial_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(f_push), .wdata(f_ent), .pop(pop),
        .rdata(q_ent), .empty(fifo_empty), .full(fifo_full)
    );

    assign rd_data = q_ent.data;
    assign rd_brk  = q_ent.brk;
    assign rd_ovr  = q_ent.ovr;
    assign rd_par  = q_ent.par;
    assign rd_frm  = q_ent.frm;
endmodule

// File: tb/serial_rx_queue_tb.sv
`timescale 1ns/1ps
module serial_rx_queue_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick16 = 1'b0;
    logic rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
    logic pop = 1'b0;
    logic [7:0] rd_data;
    logic rd_brk, rd_ovr, rd_par, rd_frm, fifo_empty, fifo_full;

    int checks = 0;
    int fails = 0;
    bit drain = 1'b0;
    bit done = 1'b0;
    logic [11:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    serial_rx_queue u_dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .pop(pop), .rd_data(rd_data),
        .rd_brk(rd_brk), .rd_ovr(rd_ovr), .rd_par(rd_par), .rd_frm(rd_frm),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full)
    );

    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tc = (tc + 1) % 4;
            tick16 = (tc == 0);
        end
    end

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops entries and compares against the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            if (pop) pop = 1'b0;
            else if (drain && !fifo_empty) begin
                if (exp_q.size() == 0) begin
                    check("R6 unexpected entry", {rd_brk, rd_ovr, rd_par, rd_frm, rd_data}, 12'hxxx);
                end else begin
                    check(tag_q.pop_front(), {rd_brk, rd_ovr, rd_par, rd_frm, rd_data}, exp_q.pop_front());
                end
                pop = 1'b1;
            end
        end
    end

    task automatic bit_out(input logic b, input int nbits);
        rxd = b;
        repeat (nbits * 64) @(negedge clk);
    endtask

    // bad: 0 none, 1 wrong parity, 2 low first stop, 3 low second stop
    task automatic send(input logic [7:0] d, input int bad, input bit store, input string tag);
        int nb;
        logic [7:0] m;
        logic pb;
        logic [11:0] e;
        nb = int'(cfg_len) + 5;
        m  = d & 8'((1 << nb) - 1);
        pb = (^m) ^ cfg_par_odd ^ (bad == 1);
        e  = {1'b0, 1'b0, cfg_par_en & (bad == 1), (bad == 2) | (bad == 3), m};
        if (store) begin
            exp_q.push_back(e);
            tag_q.push_back(tag);
        end else begin
            exp_q[exp_q.size() - 1][10] = 1'b1;
        end
        bit_out(1'b0, 1);
        for (int i = 0; i < nb; i++) bit_out(d[i], 1);
        if (cfg_par_en) bit_out(pb, 1);
        bit_out(bad != 2, 1);
        if (cfg_two_stop) bit_out(bad != 3, 1);
        bit_out(1'b1, 2);
    endtask

    task automatic wait_drained();
        repeat (200) @(negedge clk);
        while (exp_q.size() != 0 || !fifo_empty) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R9 reset state
        check("R9 empty after reset", {11'd0, fifo_empty}, 12'd1);
        check("R9 full after reset", {11'd0, fifo_full}, 12'd0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        drain = 1'b1;

        // R1 eight bits, no parity, one stop
        send(8'hA5, 0, 1, "R1 8N1 A5");
        send(8'h3C, 0, 1, "R1 8N1 3C");
        send(8'h00, 0, 1, "R1 8N1 00");
        send(8'hFF, 0, 1, "R1 8N1 FF");
        // R1 five and six bit words: upper bits read zero
        cfg_len = 2'd0;
        send(8'hFF, 0, 1, "R1 5-bit FF");
        send(8'h15, 0, 1, "R1 5-bit 15");
        cfg_len = 2'd1;
        send(8'hEA, 0, 1, "R1 6-bit EA");
        // R3 parity, seven bit words
        cfg_len = 2'd2; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        send(8'h55, 0, 1, "R3 even good");
        send(8'h2A, 1, 1, "R3 even bad");
        cfg_par_odd = 1'b1;
        send(8'h13, 0, 1, "R3 odd good");
        send(8'h40, 1, 1, "R3 odd bad");
        cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_odd = 1'b0;
        // R4 framing error on first stop
        send(8'h5A, 2, 1, "R4 stop low");
        send(8'h69, 0, 1, "R4 recover");
        // R10 two stop bits
        cfg_two_stop = 1'b1;
        send(8'h81, 0, 1, "R10 two stop good");
        send(8'h7E, 3, 1, "R10 second stop low");
        cfg_two_stop = 1'b0;
        wait_drained();

        // R2 glitch shorter than half a bit
        rxd = 1'b0;
        repeat (4 * 4) @(negedge clk);
        rxd = 1'b1;
        repeat (64 * 3) @(negedge clk);
        check("R2 glitch stores nothing", {11'd0, fifo_empty}, 12'd1);

        // R5 break: line low for 14 bit times
        exp_q.push_back({1'b1, 1'b0, 1'b0, 1'b1, 8'h00});
        tag_q.push_back("R5 break entry");
        bit_out(1'b0, 14);
        bit_out(1'b1, 2);
        send(8'h42, 0, 1, "R5 after break");
        wait_drained();

        // R8 pop on empty queue
        drain = 1'b0;
        @(negedge clk);
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        @(negedge clk);
        check("R8 still empty after pop", {11'd0, fifo_empty}, 12'd1);
        send(8'h77, 0, 1, "R8 next char intact");
        drain = 1'b1;
        wait_drained();

        // R7 overrun with 17 unread frames
        drain = 1'b0;
        for (int i = 0; i < 16; i++) send(8'(8'h10 + i), 0, 1, "R7 stored entry");
        check("R6 full at 16", {11'd0, fifo_full}, 12'd1);
        send(8'hEE, 0, 0, "");
        check("R7 still full", {11'd0, fifo_full}, 12'd1);
        drain = 1'b1;
        wait_drained();
        check("R6 empty after drain", {10'd0, fifo_empty, fifo_full}, 12'd2);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule